// File: doc/BRIEF.md
# OTG Status Word and One-Shot Timeout Timer

This block holds the on-the-go status word of a USB controller and a programmable one-shot timeout timer. It samples two level inputs from the USB core, VBUS valid and session active, keeps them in a status word and sends single-cycle events to the interrupt aggregator when VBUS validity changes or the timer runs out.

The host bus writes three word-wide registers through a select code: the timer register, a management register and the read-only status word. The timer register holds an enable bit and a 27-bit tick count in device clock cycles. It reads back the value last written, not a live count. On expiry the register is cleared to zero and a timeout event pulses. The VBUS-valid bit of the status word reads as zero unless the VBUS-detect enable bit of the management register is set. The stored bit is kept either way.

Top module: `otg_status_timer`

## Requirements
- R1: After reset the status word, the timer register and the management register read zero, and neither event output is high.
- R2: A read of the timer register (select code 1) returns the last value written to it, and it does not change while the countdown runs.
- R3: A timer write with bit 31 set and count N in bits 26:0 makes `tmo_evt` high in the sample after the (N+1)-th rising edge following the write edge. A new enabled write restarts the countdown from its own count.
- R4: On expiry the timer register reads zero and `tmo_evt` is high for exactly one cycle.
- R5: A timer write with bit 31 clear cancels any pending countdown, so no timeout event follows, and it stores the written value.
- R6: When the VBUS-valid input differs from status bit 5, bit 5 takes the new value at the next edge and `vbus_chg_evt` is high for that one cycle. No event occurs while the input matches the bit.
- R7: A rising session input sets status bit 6 (session valid) and clears bit 7 (session end). A falling session input clears bit 6 and sets bit 7. A steady level changes neither bit.
- R8: A read of the status word (select code 0) shows bit 5 as zero while management bit 9 is clear. The stored bit appears once bit 9 is set.
- R9: The management register (select code 2) reads back the last value written.
- R10: An enabled timer write with a count of zero expires at the first edge after the write edge.
- R11: Status bits other than 5, 6 and 7 read zero, select code 3 reads zero, and writes to select codes 0 and 3 have no effect.
- R12: An enabled timer write on the edge where the running countdown would expire wins: no event occurs on that edge, and the new count runs from there.

Status bit 3 (ID status) and bit 8 (power and clock good) keep their positions in the status word and read zero in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 status, 1 timer, 2 management, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source, same codes as `wr_sel` |
| rd_data | output | 32 | Combinational read data |
| vbus_valid_in | input | 1 | VBUS-valid level from the USB core |
| session_in | input | 1 | Session-active level from the USB core |
| tmo_evt | output | 1 | One-cycle timeout event |
| vbus_chg_evt | output | 1 | One-cycle VBUS-valid change event |

## Verification
Timer writes use counts of zero, one and several ticks, so an off-by-one in the expiry edge shows up as a wrong cycle count. Cancels mid-count tell a disable apart from a restart, and a rewrite on the exact expiry edge shows which of the two updates wins. The VBUS input is toggled and also held, and the management gate is switched both ways, which separates gating the stored bit from gating only the read. Session pulses of different lengths, mixed with random traffic checked cycle by cycle against a behavioural model, cover the status bits and their interaction with the timer.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  localparam int WORD_W   = 32;
  localparam int TICK_W   = 27;
  localparam int EN_POS   = 31;
  localparam int ST_VBUS  = 5;
  localparam int ST_SVAL  = 6;
  localparam int ST_SEND  = 7;
  localparam int MG_VDET  = 9;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_TIMER  = 2'd1,
    SEL_MGMT   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/otg_oneshot.sv
module otg_oneshot #(
  parameter int WORD_W = 32,
  parameter int TICK_W = 27,
  parameter int EN_POS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] val,
  output logic              tmo
);
  logic [WORD_W-1:0] val_q, val_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              arm_q, arm_d;
  logic              tmo_q, tmo_d;
  logic              upd_en;

  always_comb begin
    val_d = val_q;
    cnt_d = cnt_q;
    arm_d = arm_q;
    tmo_d = 1'b0;
    if (ld) begin
      val_d = ld_data;
      cnt_d = ld_data[TICK_W-1:0];
      arm_d = ld_data[EN_POS];
    end else if (arm_q) begin
      if (cnt_q == '0) begin
        val_d = '0;
        arm_d = 1'b0;
        tmo_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign upd_en = ld | arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (upd_en) begin
      val_q <= val_d;
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= 1'b0;
    else        tmo_q <= tmo_d;
  end

  assign val = val_q;
  assign tmo = tmo_q;

  a_r4_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (val_q == '0));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> !tmo_q);
  a_r5_cancel_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_data[EN_POS]) |=> !tmo_q);
  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (!tmo_q && val_q == $past(ld_data)));
endmodule

// File: rtl/otg_stat_track.sv
module otg_stat_track #(
  parameter int WORD_W  = 32,
  parameter int ST_VBUS = 5,
  parameter int ST_SVAL = 6,
  parameter int ST_SEND = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbus_in,
  input  logic              sess_in,
  output logic [WORD_W-1:0] stat,
  output logic              chg
);
  logic vbus_q, vbus_d;
  logic sval_q, sval_d;
  logic send_q, send_d;
  logic prev_q;
  logic chg_q, chg_d;
  logic sess_rise, sess_fall;

  assign sess_rise = sess_in & ~prev_q;
  assign sess_fall = ~sess_in & prev_q;

  always_comb begin
    vbus_d = vbus_q;
    chg_d  = 1'b0;
    if (vbus_in != vbus_q) begin
      vbus_d = vbus_in;
      chg_d  = 1'b1;
    end
    sval_d = sval_q;
    send_d = send_q;
    if (sess_rise) begin
      sval_d = 1'b1;
      send_d = 1'b0;
    end else if (sess_fall) begin
      sval_d = 1'b0;
      send_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbus_q <= 1'b0;
      sval_q <= 1'b0;
      send_q <= 1'b0;
      prev_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      vbus_q <= vbus_d;
      sval_q <= sval_d;
      send_q <= send_d;
      prev_q <= sess_in;
      chg_q  <= chg_d;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_VBUS] = vbus_q;
    stat[ST_SVAL] = sval_q;
    stat[ST_SEND] = send_q;
  end
  assign chg = chg_q;

  a_r6_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (vbus_q != $past(vbus_q)));
  a_r6_no_silent_change: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_q != $past(vbus_q)) |-> chg_q);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sval_q && send_q));
  a_r7_steady_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_in == prev_q) |=> ($stable(sval_q) && $stable(send_q)));
endmodule

// File: rtl/otg_status_timer.sv
module otg_status_timer
  import otg_tmr_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int CNT_W  = TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              vbus_valid_in,
  input  logic              session_in,
  output logic              tmo_evt,
  output logic              vbus_chg_evt
);
  logic [DATA_W-1:0] tmr_val;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] stat_view;
  logic [DATA_W-1:0] mgmt_q, mgmt_d;
  logic              tmr_ld;
  logic              mgmt_ld;

  assign tmr_ld  = wr_en && (reg_sel_e'(wr_sel) == SEL_TIMER);
  assign mgmt_ld = wr_en && (reg_sel_e'(wr_sel) == SEL_MGMT);

  otg_oneshot #(
    .WORD_W (DATA_W),
    .TICK_W (CNT_W),
    .EN_POS (EN_POS)
  ) u_oneshot (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (tmr_ld),
    .ld_data (wr_data),
    .val     (tmr_val),
    .tmo     (tmo_evt)
  );

  otg_stat_track #(
    .WORD_W  (DATA_W),
    .ST_VBUS (ST_VBUS),
    .ST_SVAL (ST_SVAL),
    .ST_SEND (ST_SEND)
  ) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .vbus_in (vbus_valid_in),
    .sess_in (session_in),
    .stat    (stat_word),
    .chg     (vbus_chg_evt)
  );

  always_comb begin
    mgmt_d = mgmt_q;
    if (mgmt_ld) mgmt_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mgmt_q <= '0;
    else if (mgmt_ld) mgmt_q <= mgmt_d;
  end

  always_comb begin
    stat_view          = stat_word;
    stat_view[ST_VBUS] = stat_word[ST_VBUS] & mgmt_q[MG_VDET];
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_STATUS: rd_data = stat_view;
      SEL_TIMER:  rd_data = tmr_val;
      SEL_MGMT:   rd_data = mgmt_q;
      default:    rd_data = '0;
    endcase
  end

  a_r8_vbus_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_sel_e'(rd_sel) == SEL_STATUS) && !mgmt_q[MG_VDET]) |-> !rd_data[ST_VBUS]);
  a_r9_mgmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_ld |=> $stable(mgmt_q));
endmodule

// File: tb/otg_status_timer_bench.sv
module otg_status_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        vbus_valid_in;
  logic        session_in;
  logic        tmo_evt;
  logic        vbus_chg_evt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otg_status_timer u_otg_status_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data),
    .vbus_valid_in (vbus_valid_in),
    .session_in    (session_in),
    .tmo_evt       (tmo_evt),
    .vbus_chg_evt  (vbus_chg_evt)
  );

  // behavioural reference
  logic [31:0] m_stat, m_tmr, m_mgmt;
  int          m_rem;
  bit          m_arm, m_prev, e_tmo, e_chg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_tmr = 0; m_mgmt = 0; m_rem = 0;
      m_arm = 0; m_prev = 0; e_tmo = 0; e_chg = 0;
    end else begin
      e_tmo = 0;
      e_chg = 0;
      if (vbus_valid_in != m_stat[5]) begin
        m_stat[5] = vbus_valid_in;
        e_chg = 1;
      end
      if (session_in && !m_prev) begin m_stat[6] = 1; m_stat[7] = 0; end
      if (!session_in && m_prev) begin m_stat[6] = 0; m_stat[7] = 1; end
      m_prev = session_in;
      if (wr_en && wr_sel == 2'd1) begin
        m_tmr = wr_data;
        m_arm = wr_data[31];
        m_rem = int'(wr_data[26:0]);
      end else if (m_arm) begin
        if (m_rem == 0) begin
          m_tmr = 0; m_arm = 0; e_tmo = 1;
        end else m_rem--;
      end
      if (wr_en && wr_sel == 2'd2) m_mgmt = wr_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: exp_rd = m_stat & ~(m_mgmt[9] ? 32'h0 : 32'h20);
      2'd1: exp_rd = m_tmr;
      2'd2: exp_rd = m_mgmt;
      default: exp_rd = 32'h0;
    endcase
  endfunction

  // cycle-by-cycle comparison
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      case (rd_sel)
        2'd0: chk("R7 status word", rd_data, exp_rd(rd_sel));
        2'd1: chk("R2 timer readback", rd_data, exp_rd(rd_sel));
        2'd2: chk("R9 mgmt readback", rd_data, exp_rd(rd_sel));
        default: chk("R11 unused select", rd_data, exp_rd(rd_sel));
      endcase
      chk("R4 timeout event", {31'b0, tmo_evt}, {31'b0, e_tmo});
      chk("R6 vbus change event", {31'b0, vbus_chg_evt}, {31'b0, e_chg});
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_tmo(output int k);
    k = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #3;
      k++;
      if (tmo_evt) break;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_sel = rd_sel + 2'd1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int k;
    bit seen;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    vbus_valid_in = 0; session_in = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s); #1;
      chk("R1 reset read", rd_data, 32'h0);
    end
    chk("R1 reset events", {30'b0, tmo_evt, vbus_chg_evt}, 32'h0);
    @(negedge clk); rst_n = 1;
    idle(4);

    // R3: count 5 expires on the 6th edge
    rd_sel = 2'd1;
    wr(2'd1, 32'h8000_0005);
    chk("R2 readback while running", rd_data, 32'h8000_0005);
    wait_tmo(k);
    chk("R3 expiry edge count", k, 6);
    chk("R4 register cleared", rd_data, 32'h0);

    // R10: count zero
    @(negedge clk);
    wr(2'd1, 32'h8000_0000);
    wait_tmo(k);
    chk("R10 zero count expiry", k, 1);

    // R3 restart mid-count
    @(negedge clk);
    wr(2'd1, 32'h8000_0008);
    idle(3);
    rd_sel = 2'd1;
    wr(2'd1, 32'h8000_0002);
    wait_tmo(k);
    chk("R3 restart from new count", k, 3);

    // R12: rewrite on the expiry edge
    @(negedge clk);
    wr(2'd1, 32'h8000_0003);
    repeat (2) @(negedge clk);
    wr(2'd1, 32'h8000_0002);
    wait_tmo(k);
    chk("R12 rewrite wins on expiry edge", k, 3);

    // R5: cancel
    @(negedge clk);
    rd_sel = 2'd1;
    wr(2'd1, 32'h8000_0004);
    wr(2'd1, 32'h0000_0004);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #3;
      if (tmo_evt) seen = 1;
    end
    chk("R5 no event after cancel", {31'b0, seen}, 32'h0);
    chk("R5 cancel value kept", rd_data, 32'h0000_0004);

    // R6 / R8: vbus with gate clear then set
    @(negedge clk);
    rd_sel = 2'd0;
    vbus_valid_in = 1;
    @(posedge clk); #3;
    chk("R6 change pulse", {31'b0, vbus_chg_evt}, 32'h1);
    chk("R8 gated read", {31'b0, rd_data[5]}, 32'h0);
    @(posedge clk); #3;
    chk("R6 no pulse when steady", {31'b0, vbus_chg_evt}, 32'h0);
    wr(2'd2, 32'h0000_0200);
    #1;
    chk("R8 ungated read", {31'b0, rd_data[5]}, 32'h1);

    // R7: session
    @(negedge clk); session_in = 1;
    @(posedge clk); #3;
    chk("R7 session valid set", {30'b0, rd_data[7:6]}, 32'h1);
    repeat (3) @(negedge clk);
    session_in = 0;
    @(posedge clk); #3;
    chk("R7 session end set", {30'b0, rd_data[7:6]}, 32'h2);

    // R11: writes to status and unused codes ignored
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    #1;
    chk("R11 status not writable", rd_data, 32'h0000_00A0);
    rd_sel = 2'd3; #1;
    chk("R11 unused reads zero", rd_data, 32'h0);

    // random traffic checked against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) vbus_valid_in = ~vbus_valid_in;
      if ($urandom_range(0, 7) == 0) session_in = ~session_in;
      wr_en = ($urandom_range(0, 5) == 0);
      wr_sel = 2'($urandom_range(0, 3));
      wr_data = {1'($urandom_range(0, 1)), 4'($urandom), 27'($urandom_range(0, 12))};
      if (wr_sel == 2'd2) wr_data[9] = 1'($urandom_range(0, 1));
    end
    @(negedge clk); wr_en = 0;
    idle(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule